// File: doc/BRIEF.md
# Serial EEPROM Boot Loader

This block fills a small on-chip register file from a 16-word by 16-bit serial EEPROM once the power-on-reset qualifier has been seen and released. The register file is read by the host as a station-address ROM of sixteen bytes. The loader talks to the EEPROM over a synchronous serial link with chip select, a serial clock, a data line towards the device and a data line back from it. The serial clock comes from the system clock through a parameterised divider.

While the qualifier is high, the block latches three configuration bytes and a "configuration from EEPROM" strap from its strap inputs. When the qualifier falls, the block starts its load. If the strap was high, it first reads the top two EEPROM words and replaces the three configuration bytes with their contents. It always reads the top word, because the upper byte of that word holds a protection code. The block compares that byte with 73h and reports the result as a lock status bit. It then reads words 0 to 7 into the ROM file.

For the whole load the block raises a busy flag. While busy is high, the ROM read port returns zero, so the host cannot reach half-loaded data.

Top module: `nvm_boot_loader`

## Requirements
- R1: No serial activity takes place and busy stays low unless the qualifier input has been high and then gone low. A synchronous reset on its own never starts a load.
- R2: Busy is high in the cycle after the qualifier falls. It stays high until the last word is captured, then returns low. After reset, busy, the configuration outputs, the lock bit and all ROM bytes are zero.
- R3: Each word read is one frame, shifted on rising serial-clock edges. The frame is a start bit of 1, then opcode bits 1 and 0, then the 4-bit word address MSB first. The device returns a zero dummy bit, then 16 data bits MSB first. A frame has 23 serial-clock rising edges in total.
- R4: With the strap high, the read order is word 14 (0Eh), then word 15 (0Fh), then words 0 to 7. With the strap low, the order is word 15, then words 0 to 7.
- R5: ROM byte address 2k returns bits 7:0 of EEPROM word k, and byte address 2k+1 returns bits 15:8, for k from 0 to 7. The read port is 4 bits wide.
- R6: While the qualifier is high, the configuration outputs follow the strap bytes. Once the qualifier is low, later strap changes have no effect. With the strap low, the latched strap bytes survive the load.
- R7: With the strap high, configuration byte A takes bits 7:0 of word 14, B takes bits 15:8 of word 14, and C takes bits 7:0 of word 15.
- R8: The lock output is 1 exactly when bits 15:8 of word 15 equal 73h. This holds for both strap levels.
- R9: Each serial-clock half period lasts CLK_DIV system cycles. The serial clock is high only while chip select is high. Chip select goes low between words, so each word has its own chip-select pulse.
- R10: While busy is high, the ROM read port returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| por_valid_i | input | 1 | Qualified power-on-reset indication; its falling edge starts the load |
| strap_nvm_cfg_i | input | 1 | Strap: take configuration from the EEPROM |
| strap_cfg_a_i | input | 8 | Strap value for configuration byte A |
| strap_cfg_b_i | input | 8 | Strap value for configuration byte B |
| strap_cfg_c_i | input | 8 | Strap value for configuration byte C |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data towards the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| busy_o | output | 1 | Load in progress; host access blocked |
| cfg_a_o | output | 8 | Configuration byte A |
| cfg_b_o | output | 8 | Configuration byte B |
| cfg_c_o | output | 8 | Configuration byte C |
| lock_ok_o | output | 1 | Protection code present (1 = locked) |
| rom_addr_i | input | 4 | ROM byte address |
| rom_data_o | output | 8 | ROM byte data |

## Verification
The bench runs three loads, each with a different EEPROM image:
- **Strap low, code present.** The read order must skip word 14, and the strap bytes must survive the load.
- **Strap high, code wrong.** Words 14 and 15 must be fetched first and must replace the strap bytes, and the lock bit must drop.
- **Strap low, code wrong.** This separates the lock decision from the strap level.

Each image has distinct bytes in every position, so a swapped half-word or a shifted bit shows up in the ROM byte comparison. A reset with no qualifier pulse, and strap changes after the qualifier falls, show that neither one alters the outputs.

// File: rtl/nvmb_pkg.sv
package nvmb_pkg;

    localparam int NV_WORDS  = 16;
    localparam int NV_AW     = $clog2(NV_WORDS);
    localparam int DATA_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int ROM_WORDS = 8;
    localparam int ROM_IW    = $clog2(ROM_WORDS);
    localparam int ROM_AW    = $clog2(ROM_WORDS * 2);
    localparam int CMD_W     = 3 + NV_AW;
    localparam int SLOTS     = CMD_W + DATA_W;
    localparam int N_STEPS   = ROM_WORDS + 2;
    localparam int STEP_W    = $clog2(N_STEPS);

    localparam logic [STEP_W-1:0] STEP_CFG  = STEP_W'(0);
    localparam logic [STEP_W-1:0] STEP_LOCK = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_ROM0 = STEP_W'(2);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(N_STEPS - 1);

    localparam logic [BYTE_W-1:0] LOCK_CODE = 8'h73;

    typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI, PH_GAP} phase_t;
    typedef enum logic [1:0] {LD_IDLE, LD_ISSUE, LD_WAIT}   ld_t;

    typedef struct packed {
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [BYTE_W-1:0] c;
    } cfg_t;

    // Word address for a load step: config word, lock word, then ROM words.
    function automatic logic [NV_AW-1:0] step_addr(input logic [STEP_W-1:0] step);
        logic [STEP_W-1:0] rel;
        if (step == STEP_CFG)       return NV_AW'(NV_WORDS - 2);
        else if (step == STEP_LOCK) return NV_AW'(NV_WORDS - 1);
        rel = step - STEP_ROM0;
        return NV_AW'(rel);
    endfunction

    // Start bit, read opcode, address.
    function automatic logic [CMD_W-1:0] rd_cmd(input logic [NV_AW-1:0] addr);
        return {1'b1, 2'b10, addr};
    endfunction

endpackage

// File: rtl/nvmb_tick.sv
module nvmb_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nvmb_frame.sv
module nvmb_frame
    import nvmb_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start,
    input  logic [NV_AW-1:0]  addr,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              cs,
    output logic              sk,
    output logic              di,
    input  logic              do_i
);
    localparam int SLOT_W = $clog2(SLOTS + 1);

    phase_t            ph;
    logic [SLOT_W-1:0] slot;
    logic [CMD_W-1:0]  cmd_sr;
    logic              tick;
    logic              tick_clr;

    assign tick_clr = (ph == PH_IDLE);

    nvmb_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (tick_clr),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            ph     <= PH_IDLE;
            slot   <= '0;
            cmd_sr <= '0;
            word   <= '0;
            done   <= 1'b0;
            cs     <= 1'b0;
            sk     <= 1'b0;
            di     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: if (start) begin
                    cs     <= 1'b1;
                    sk     <= 1'b0;
                    di     <= rd_cmd(addr)[CMD_W-1];
                    cmd_sr <= rd_cmd(addr) << 1;
                    slot   <= '0;
                    ph     <= PH_LO;
                end
                PH_LO: if (tick) begin
                    sk <= 1'b1;
                    ph <= PH_HI;
                end
                PH_HI: if (tick) begin
                    sk <= 1'b0;
                    // last command slot samples the dummy bit; it leaves the window
                    if (int'(slot) >= CMD_W - 1)
                        word <= {word[DATA_W-2:0], do_i};
                    if (int'(slot) == SLOTS - 1) begin
                        cs <= 1'b0;
                        di <= 1'b0;
                        ph <= PH_GAP;
                    end else begin
                        slot   <= slot + 1'b1;
                        di     <= cmd_sr[CMD_W-1];
                        cmd_sr <= cmd_sr << 1;
                        ph     <= PH_LO;
                    end
                end
                PH_GAP: if (tick) begin
                    done <= 1'b1;
                    ph   <= PH_IDLE;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nvmb_rom.sv
module nvmb_rom
    import nvmb_pkg::*;
#(
    parameter int WORDS = ROM_WORDS,
    parameter int IW    = $clog2(WORDS),
    parameter int AW    = $clog2(WORDS * 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IW-1:0]     widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [WORDS*DATA_W-1:0] flat;
    logic [DATA_W-1:0]       sel;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)                              q <= '0;
            else if (we && (widx == IW'(g)))      q <= wdata;
        end
        assign flat[g*DATA_W +: DATA_W] = q;
    end

    assign sel   = flat[raddr[AW-1:1]*DATA_W +: DATA_W];
    assign rdata = raddr[0] ? sel[DATA_W-1:BYTE_W] : sel[BYTE_W-1:0];
endmodule

// File: rtl/nvm_boot_loader.sv
module nvm_boot_loader
    import nvmb_pkg::*;
#(
    parameter int CLK_DIV = 125
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_valid_i,
    input  logic              strap_nvm_cfg_i,
    input  logic [7:0]        strap_cfg_a_i,
    input  logic [7:0]        strap_cfg_b_i,
    input  logic [7:0]        strap_cfg_c_i,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    input  logic              ee_do_i,
    output logic              busy_o,
    output logic [7:0]        cfg_a_o,
    output logic [7:0]        cfg_b_o,
    output logic [7:0]        cfg_c_o,
    output logic              lock_ok_o,
    input  logic [ROM_AW-1:0] rom_addr_i,
    output logic [7:0]        rom_data_o
);
    logic              por_q;
    logic              start_evt;
    ld_t               st;
    logic [STEP_W-1:0] step;
    logic              use_nvm;
    cfg_t              cfg;
    logic              lock_ok;
    logic              busy;

    logic              fr_start;
    logic              fr_done;
    logic [DATA_W-1:0] fr_word;
    logic [NV_AW-1:0]  fr_addr;

    logic              rom_we;
    logic [STEP_W-1:0] rom_rel;
    logic [ROM_IW-1:0] rom_widx;
    logic [7:0]        rom_rd;

    // Previous qualifier level is kept through reset so a fall is never missed.
    always_ff @(posedge clk) por_q <= por_valid_i;

    assign start_evt = por_q && !por_valid_i;
    assign fr_start  = (st == LD_ISSUE);
    assign fr_addr   = step_addr(step);

    nvmb_frame #(.DIV(CLK_DIV)) u_frame (
        .clk   (clk),
        .rst   (rst),
        .abort (start_evt),
        .start (fr_start),
        .addr  (fr_addr),
        .done  (fr_done),
        .word  (fr_word),
        .cs    (ee_cs_o),
        .sk    (ee_sk_o),
        .di    (ee_di_o),
        .do_i  (ee_do_i)
    );

    assign rom_we   = (st == LD_WAIT) && fr_done && (step >= STEP_ROM0);
    assign rom_rel  = step - STEP_ROM0;
    assign rom_widx = rom_rel[ROM_IW-1:0];

    nvmb_rom #(.WORDS(ROM_WORDS)) u_rom (
        .clk   (clk),
        .rst   (rst),
        .we    (rom_we),
        .widx  (rom_widx),
        .wdata (fr_word),
        .raddr (rom_addr_i),
        .rdata (rom_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LD_IDLE;
            step    <= '0;
            use_nvm <= 1'b0;
            cfg     <= '0;
            lock_ok <= 1'b0;
            busy    <= 1'b0;
        end else begin
            if (por_valid_i) begin
                cfg     <= '{a: strap_cfg_a_i, b: strap_cfg_b_i, c: strap_cfg_c_i};
                use_nvm <= strap_nvm_cfg_i;
            end
            if (start_evt) begin
                busy <= 1'b1;
                st   <= LD_ISSUE;
                step <= use_nvm ? STEP_CFG : STEP_LOCK;
            end else begin
                unique case (st)
                    LD_ISSUE: st <= LD_WAIT;
                    LD_WAIT: if (fr_done) begin
                        if (step == STEP_CFG) begin
                            cfg.a <= fr_word[BYTE_W-1:0];
                            cfg.b <= fr_word[DATA_W-1:BYTE_W];
                        end
                        if (step == STEP_LOCK) begin
                            if (use_nvm) cfg.c <= fr_word[BYTE_W-1:0];
                            lock_ok <= (fr_word[DATA_W-1:BYTE_W] == LOCK_CODE);
                        end
                        if (step == STEP_LAST) begin
                            st   <= LD_IDLE;
                            busy <= 1'b0;
                        end else begin
                            step <= step + 1'b1;
                            st   <= LD_ISSUE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy_o     = busy;
    assign cfg_a_o    = cfg.a;
    assign cfg_b_o    = cfg.b;
    assign cfg_c_o    = cfg.c;
    assign lock_ok_o  = lock_ok;
    assign rom_data_o = busy ? 8'h00 : rom_rd;
endmodule

// File: rtl/nvmb_checker.sv
module nvmb_checker (
    input logic clk,
    input logic rst,
    input logic por_valid_i,
    input logic busy_o,
    input logic ee_cs_o,
    input logic ee_sk_o,
    input logic ee_di_o
);
    // R2: a qualifier fall starts the load on the next cycle
    a_r2_busy_after_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(por_valid_i) |=> busy_o);

    // R1: the serial link stays idle outside a load
    a_r1_cs_needs_busy: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ee_cs_o);

    // R9: serial clock only inside a chip-select window
    a_r9_sk_within_cs: assert property (@(posedge clk) disable iff (rst)
        ee_sk_o |-> ee_cs_o);

    // R3: data towards the device is steady while the serial clock is high
    a_r3_di_steady_high: assert property (@(posedge clk) disable iff (rst)
        ee_sk_o |-> $stable(ee_di_o));

    // R2: the load ends with the serial clock parked low
    a_r2_end_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (!ee_sk_o && !ee_cs_o));
endmodule

bind nvm_boot_loader nvmb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .por_valid_i (por_valid_i),
    .busy_o      (busy_o),
    .ee_cs_o     (ee_cs_o),
    .ee_sk_o     (ee_sk_o),
    .ee_di_o     (ee_di_o)
);

// File: tb/nvm_boot_loader_tb.sv
module nvm_boot_loader_tb;
    import nvmb_pkg::*;

    localparam int DIV = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst = 1'b1, por = 1'b0, strap_nvm = 1'b0;
    logic [7:0]       sa = '0, sb = '0, sc = '0;
    logic             ee_cs, ee_sk, ee_di, ee_do = 1'b0;
    logic             busy, lock_ok;
    logic [7:0]       ca, cb, cc, rom_data;
    logic [ROM_AW-1:0] rom_addr = '0;

    nvm_boot_loader #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .por_valid_i(por), .strap_nvm_cfg_i(strap_nvm),
        .strap_cfg_a_i(sa), .strap_cfg_b_i(sb), .strap_cfg_c_i(sc),
        .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di), .ee_do_i(ee_do),
        .busy_o(busy), .cfg_a_o(ca), .cfg_b_o(cb), .cfg_c_o(cc),
        .lock_ok_o(lock_ok), .rom_addr_i(rom_addr), .rom_data_o(rom_data));

    int errs = 0, checks = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- EEPROM model and scoreboard monitor ----------------
    logic [DATA_W-1:0] mem [NV_WORDS];
    logic [NV_AW-1:0]  exp_q [$];
    logic [CMD_W-1:0]  cbits;
    logic [NV_AW-1:0]  cur;
    int rcnt = 0, frames = 0, cyc = 0, last_rise = 0, bad_period = 0;

    always @(posedge clk) cyc++;

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            rcnt = 0;
        end else begin
            rcnt++;
            if (rcnt > 1 && (cyc - last_rise) != 2 * DIV) bad_period++;
            last_rise = cyc;
            if (rcnt <= CMD_W) cbits = {cbits[CMD_W-2:0], ee_di};
            if (rcnt == CMD_W) begin
                frames++;
                cur = cbits[NV_AW-1:0];
                chk(cbits[CMD_W-1] == 1'b1, "R3", "start bit", int'(cbits[CMD_W-1]), 1);
                chk(cbits[CMD_W-2 -: 2] == 2'b10, "R3", "opcode", int'(cbits[CMD_W-2 -: 2]), 2);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected word read", int'(cur), -1);
                end else begin
                    logic [NV_AW-1:0] e;
                    e = exp_q.pop_front();
                    chk(cur == e, "R4", "word order", int'(cur), int'(e));
                end
                ee_do <= 1'b0;
            end else if (rcnt > CMD_W && rcnt <= CMD_W + DATA_W) begin
                ee_do <= mem[cur][DATA_W - (rcnt - CMD_W)];
            end else if (rcnt > CMD_W + DATA_W) begin
                chk(1'b0, "R3", "too many clocks in frame", rcnt, CMD_W + DATA_W);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic fill(input int seed, input bit locked);
        for (int k = 0; k < NV_WORDS; k++)
            mem[k] = {8'(k * 37 + seed), 8'(k * 11 + seed * 3 + 1)};
        mem[NV_WORDS-1][15:8] = locked ? 8'h73 : 8'h5C;
    endtask

    task automatic run_load(input bit nvm, input logic [7:0] a, b, c,
                            input int seed, input bit locked);
        int f0, n;
        logic [7:0] ea, eb, ec;
        fill(seed, locked);
        if (nvm) exp_q.push_back(NV_AW'(NV_WORDS - 2));
        exp_q.push_back(NV_AW'(NV_WORDS - 1));
        for (int k = 0; k < ROM_WORDS; k++) exp_q.push_back(NV_AW'(k));
        f0 = frames;
        bad_period = 0;

        @(negedge clk);
        strap_nvm = nvm; sa = a; sb = b; sc = c; por = 1'b1;
        repeat (3) @(negedge clk);
        chk(ca == a && cb == b && cc == c, "R6", "cfg follows straps", int'({ca, cb, cc}), int'({a, b, c}));
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R2", "busy after qualifier fall", int'(busy), 1);
        rom_addr = 4'd1;
        #1;
        chk(rom_data == 8'h00, "R10", "rom blocked while busy", int'(rom_data), 0);
        sa = ~a; sb = ~b; sc = ~c; strap_nvm = ~nvm;   // must have no effect now

        n = 0;
        while (busy && n < 50000) begin @(negedge clk); n++; end
        chk(!busy, "R2", "busy cleared at end", int'(busy), 0);
        repeat (3) @(negedge clk);

        chk(exp_q.size() == 0, "R4", "all expected words read", exp_q.size(), 0);
        exp_q.delete();
        chk(frames - f0 == (nvm ? 10 : 9), "R9", "one chip-select pulse per word", frames - f0, nvm ? 10 : 9);
        chk(bad_period == 0, "R9", "serial clock period", bad_period, 0);
        chk(!ee_cs && !ee_sk, "R9", "link idle after load", int'({ee_cs, ee_sk}), 0);

        if (nvm) begin
            ea = mem[NV_WORDS-2][7:0]; eb = mem[NV_WORDS-2][15:8]; ec = mem[NV_WORDS-1][7:0];
            chk(ca == ea && cb == eb && cc == ec, "R7", "cfg from eeprom", int'({ca, cb, cc}), int'({ea, eb, ec}));
        end else begin
            chk(ca == a && cb == b && cc == c, "R6", "strap cfg kept", int'({ca, cb, cc}), int'({a, b, c}));
        end
        chk(lock_ok == locked, "R8", "lock status", int'(lock_ok), int'(locked));

        for (int k = 0; k < 2 * ROM_WORDS; k++) begin
            logic [7:0] eb8;
            @(negedge clk);
            rom_addr = ROM_AW'(k);
            #1;
            eb8 = (k % 2) ? mem[k / 2][15:8] : mem[k / 2][7:0];
            chk(rom_data == eb8, "R5", $sformatf("rom byte %0d", k), int'(rom_data), int'(eb8));
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !lock_ok, "R2", "reset busy/lock", int'({busy, lock_ok}), 0);
        chk(ca == 0 && cb == 0 && cc == 0, "R2", "reset cfg", int'({ca, cb, cc}), 0);
        #1;
        chk(rom_data == 0, "R2", "reset rom byte", int'(rom_data), 0);

        // R1: reset alone, straps moving, qualifier never high
        sa = 8'h5A; sb = 8'hA5; sc = 8'h3C;
        repeat (300) @(negedge clk);
        chk(frames == 0 && !busy, "R1", "no load without qualifier", frames, 0);
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        repeat (300) @(negedge clk);
        chk(frames == 0 && !busy && !ee_cs, "R1", "reset pulse starts nothing", frames, 0);
        chk(ca == 0, "R6", "straps ignored with qualifier low", int'(ca), 0);

        run_load(1'b0, 8'h11, 8'h22, 8'h33, 5,  1'b1);
        run_load(1'b1, 8'h44, 8'h55, 8'h66, 91, 1'b0);
        run_load(1'b0, 8'h77, 8'h88, 8'h99, 47, 1'b0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule